// File: doc/BRIEF.md
# Decimating FIR Filter with Programmable Coefficient RAM

This block filters a complex (I/Q) sample stream with a decimating FIR whose coefficients live in a small internal RAM. A single fast clock drives everything. Input samples arrive now and then, each marked by a one-cycle valid strobe. Each path (I and Q) has one multiply-accumulate unit, which works through the taps one per clock cycle. After every M accepted samples the filter emits one rounded, scaled and saturated output pair with a one-cycle valid strobe.

Software programs the filter through a plain write port. That port loads the 64-entry coefficient RAM and three control words: the tap count, a control word (decimation rate, output phase, symmetric mode, output attenuation, bypass) and a base offset into the RAM. Several filters can sit in the RAM at once. Moving the base offset switches between them, and the switch always happens at an output-sample boundary.

Top module: `ramfir_top`

## Requirements
- R1: After reset `outValid` is 0 and `outI`/`outQ` are 0. The defaults are: one tap, rate 1, phase 0, asymmetric, scale code 11, bypass off, offset 0, and every coefficient 0.
- R2: Write port map (`regAddr`):
  - 0–63 write coefficient entry `regAddr[5:0]`.
  - 64 writes the tap count minus one from `regData[6:0]`.
  - 65 writes the control word: `[3:0]` rate minus one, `[7:4]` output phase, `[8]` symmetric, `[10:9]` scale code, `[11]` bypass.
  - 66 writes the coefficient base offset from `regData[5:0]`.
  - A write to address 65 restarts the count of accepted samples at zero.
- R3: Asymmetric mode with N taps (N ≤ 64) computes y[n] = Σ c[(off+k) mod 64]·x[n−k] for k = 0..N−1.
- R4: With rate M, an output is started only by an accepted sample whose index, counted from the last control write, modulo M equals the phase field. All other samples produce no output.
- R5: Symmetric mode with N taps (N ≤ 128) uses ceil(N/2) stored coefficients. For each k the two samples x[n−k] and x[n−(N−1−k)] are added before the multiply. For odd N the centre tap uses its single sample.
- R6: The accumulated sum is shifted right arithmetically by 22 − scale, with round-half-up, then saturated to 20-bit signed. Scale code 11 gives no attenuation; codes 10, 01 and 00 each add one further halving.
- R7: With bypass set, every accepted sample is copied unchanged to the outputs on the same clock edge that accepts it. No decimation and no scaling apply.
- R8: The base offset is captured when an output computation starts. An offset write during the computation affects only the next output.
- R9: A filtered output becomes valid ceil-count + 1 clock edges after the accepting edge, where the count is the number of stored coefficients used (N asymmetric, ceil(N/2) symmetric). The next accepted sample must come at least that count + 3 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast processing clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 20 | Input I sample, signed |
| inQ | input | 20 | Input Q sample, signed |
| regWe | input | 1 | Register / coefficient write enable |
| regAddr | input | 7 | Write address |
| regData | input | 20 | Write data |
| outValid | output | 1 | Output sample strobe |
| outI | output | 20 | Output I sample, signed |
| outQ | output | 20 | Output Q sample, signed |

## Verification
A base-offset write can land in the same cycle that the MAC sequencer is reading coefficients for an output that is already in progress. The bench provokes this by programming two distinct coefficient sets at RAM bases 0 and 32. It feeds a triggering sample, then writes the new offset three cycles later, while the eight-tap run is still underway. The output in progress must match a reference built entirely from the old set, and the following output must match the new set exactly.

// File: rtl/ramfir_pkg.sv
package ramfir_pkg;
  localparam int DATA_W     = 20;
  localparam int COEF_W     = 20;
  localparam int COEF_AW    = 6;
  localparam int COEF_DEPTH = 1 << COEF_AW;
  localparam int HIST_AW    = 7;
  localparam int HIST_DEPTH = 1 << HIST_AW;
  localparam int ACC_W      = 48;
  localparam int REG_AW     = 7;
  localparam int NUM_PATH   = 2;
  localparam int PROD_W     = DATA_W + COEF_W + 1;
  localparam int FRAC_W     = COEF_W - 1;

  localparam logic [REG_AW-1:0] ADDR_TAPS = REG_AW'(64);
  localparam logic [REG_AW-1:0] ADDR_CTRL = REG_AW'(65);
  localparam logic [REG_AW-1:0] ADDR_OFFS = REG_AW'(66);

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_MAC, SEQ_DONE} seq_e;

  typedef struct packed {
    logic                sampleWe;
    logic                coefWe;
    logic [COEF_AW-1:0]  coefAddr;
    logic [COEF_W-1:0]   coefData;
    logic                start;
    logic                macEn;
    logic                finish;
    logic [COEF_AW-1:0]  coefIdx;
    logic [HIST_AW-1:0]  nearIdx;
    logic [HIST_AW-1:0]  farIdx;
    logic                usePair;
    logic [1:0]          scale;
    logic                bypass;
  } strobe_t;
endpackage

// File: rtl/ramfir_ctrl.sv
module ramfir_ctrl
  import ramfir_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regData,
  output strobe_t           stb
);
  // programmed settings
  logic [HIST_AW-1:0] tapsM1;
  logic [3:0]         rateM1;
  logic [3:0]         phaseSel;
  logic               symOn;
  logic [1:0]         scaleSel;
  logic               bypassOn;
  logic [COEF_AW-1:0] baseOff;
  logic [3:0]         phaseCnt;

  // settings frozen for the running computation
  seq_e               state;
  logic [COEF_AW-1:0] k;
  logic [COEF_AW-1:0] runLast;
  logic [HIST_AW-1:0] runTapsM1;
  logic               runSym;
  logic [COEF_AW-1:0] runOff;
  logic [1:0]         runScale;

  logic               ctrlWr;
  logic               trigger;
  logic [COEF_AW-1:0] lastIdx;
  logic [HIST_AW-1:0] kWide;

  assign ctrlWr  = regWe && (regAddr == ADDR_CTRL);
  assign trigger = inValid && !bypassOn && (phaseCnt == phaseSel) && (state == SEQ_IDLE);
  assign lastIdx = symOn ? tapsM1[HIST_AW-1:1] : tapsM1[COEF_AW-1:0];
  assign kWide   = HIST_AW'(k);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapsM1   <= '0;
      rateM1   <= '0;
      phaseSel <= '0;
      symOn    <= 1'b0;
      scaleSel <= 2'b11;
      bypassOn <= 1'b0;
      baseOff  <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_TAPS) tapsM1 <= regData[HIST_AW-1:0];
      if (regAddr == ADDR_OFFS) baseOff <= regData[COEF_AW-1:0];
      if (ctrlWr) begin
        rateM1   <= regData[3:0];
        phaseSel <= regData[7:4];
        symOn    <= regData[8];
        scaleSel <= regData[10:9];
        bypassOn <= regData[11];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlWr) phaseCnt <= '0;
    else if (inValid)    phaseCnt <= (phaseCnt == rateM1) ? 4'd0 : phaseCnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      k         <= '0;
      runLast   <= '0;
      runTapsM1 <= '0;
      runSym    <= 1'b0;
      runOff    <= '0;
      runScale  <= 2'b11;
    end else begin
      unique case (state)
        SEQ_IDLE: if (trigger) begin
          state     <= SEQ_MAC;
          k         <= '0;
          runLast   <= lastIdx;
          runTapsM1 <= tapsM1;
          runSym    <= symOn;
          runOff    <= baseOff;
          runScale  <= scaleSel;
        end
        SEQ_MAC: begin
          k <= k + 1'b1;
          if (k == runLast) state <= SEQ_DONE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.sampleWe = inValid;
    stb.coefWe   = regWe && !regAddr[REG_AW-1];
    stb.coefAddr = regAddr[COEF_AW-1:0];
    stb.coefData = regData;
    stb.start    = trigger;
    stb.macEn    = (state == SEQ_MAC);
    stb.finish   = (state == SEQ_DONE);
    stb.coefIdx  = runOff + k;
    stb.nearIdx  = kWide;
    stb.farIdx   = runTapsM1 - kWide;
    stb.usePair  = runSym && (stb.farIdx != kWide);
    stb.scale    = runScale;
    stb.bypass   = bypassOn;
  end
endmodule

// File: rtl/ramfir_lane.sv
module ramfir_lane
  import ramfir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleWe,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [HIST_AW-1:0]       wrPtr,
  input  logic [HIST_AW-1:0]       basePtr,
  input  logic                     start,
  input  logic                     macEn,
  input  logic [HIST_AW-1:0]       nearIdx,
  input  logic [HIST_AW-1:0]       farIdx,
  input  logic                     usePair,
  input  logic signed [COEF_W-1:0] coef,
  input  logic [1:0]               scale,
  output logic signed [DATA_W-1:0] result
);
  logic signed [DATA_W-1:0] hist [HIST_DEPTH];
  logic signed [DATA_W-1:0] nearS, farS;
  logic signed [DATA_W:0]   sumS;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  rndSum, shifted;
  logic [5:0]               shAmt;
  logic                     inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HIST_DEPTH; i++) hist[i] <= '0;
    end else if (sampleWe) begin
      hist[wrPtr] <= sampleIn;
    end
  end

  always_comb begin
    nearS = hist[basePtr - nearIdx];
    farS  = usePair ? hist[basePtr - farIdx] : '0;
    sumS  = {nearS[DATA_W-1], nearS} + {farS[DATA_W-1], farS};
    prod  = sumS * coef;
  end

  always_ff @(posedge clk) begin
    if (!rstN || start) acc <= '0;
    else if (macEn)     acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  // single rounding step: fraction bits plus attenuation in one shift
  always_comb begin
    shAmt   = 6'(FRAC_W + 3) - {4'b0, scale};
    rndSum  = acc + (ACC_W'(1) << (shAmt - 6'd1));
    shifted = rndSum >>> shAmt;
    inRange = (shifted[ACC_W-1:DATA_W-1] == '0) || (shifted[ACC_W-1:DATA_W-1] == '1);
    if (inRange)                result = shifted[DATA_W-1:0];
    else if (shifted[ACC_W-1])  result = {1'b1, {(DATA_W-1){1'b0}}};
    else                        result = {1'b0, {(DATA_W-1){1'b1}}};
  end
endmodule

// File: rtl/ramfir_datapath.sv
module ramfir_datapath
  import ramfir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  logic [COEF_W-1:0]        coefMem [COEF_DEPTH];
  logic [HIST_AW-1:0]       wrPtr, basePtr;
  logic signed [COEF_W-1:0] coefNow;
  logic signed [DATA_W-1:0] laneIn  [NUM_PATH];
  logic signed [DATA_W-1:0] laneRes [NUM_PATH];

  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;
  assign coefNow   = $signed(coefMem[stb.coefIdx]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < COEF_DEPTH; i++) coefMem[i] <= '0;
    end else if (stb.coefWe) begin
      coefMem[stb.coefAddr] <= stb.coefData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      basePtr <= '0;
    end else begin
      if (stb.start)    basePtr <= wrPtr;
      if (stb.sampleWe) wrPtr   <= wrPtr + 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    ramfir_lane u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .sampleWe (stb.sampleWe),
      .sampleIn (laneIn[p]),
      .wrPtr    (wrPtr),
      .basePtr  (basePtr),
      .start    (stb.start),
      .macEn    (stb.macEn),
      .nearIdx  (stb.nearIdx),
      .farIdx   (stb.farIdx),
      .usePair  (stb.usePair),
      .coef     (coefNow),
      .scale    (stb.scale),
      .result   (laneRes[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= 1'b0;
      if (stb.sampleWe && stb.bypass) begin
        outValid <= 1'b1;
        outI     <= inI;
        outQ     <= inQ;
      end else if (stb.finish) begin
        outValid <= 1'b1;
        outI     <= laneRes[0];
        outQ     <= laneRes[1];
      end
    end
  end
endmodule

// File: rtl/ramfir_top.sv
module ramfir_top
  import ramfir_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic                     regWe,
  input  logic [REG_AW-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  strobe_t stb;

  ramfir_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regData (regData),
    .stb     (stb)
  );

  ramfir_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inI      (inI),
    .inQ      (inQ),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ)
  );
endmodule

// File: rtl/ramfir_checker.sv
module ramfir_checker
  import ramfir_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic signed [DATA_W-1:0] inI,
  input logic signed [DATA_W-1:0] inQ,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ,
  input logic                     sampleWe,
  input logic                     bypass,
  input logic                     start,
  input logic                     macEn,
  input logic                     finish,
  input logic [COEF_AW-1:0]       coefIdx
);
  // R9: a finished run always yields an output on the next edge
  p_finish_emits_r9: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> outValid);

  // R4: no output appears without a finished run or a bypassed sample
  p_valid_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(finish) || $past(sampleWe && bypass)));

  // R7: bypassed samples reach the outputs unchanged
  p_bypass_passthru_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleWe && bypass) |=> (outValid && outI == $past(inI) && outQ == $past(inQ)));

  // R8: coefficient addresses walk contiguously; an offset write cannot jump them
  p_offset_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (macEn && $past(macEn)) |-> (coefIdx == $past(coefIdx) + 1'b1));

  // R3: an accepted trigger enters the tap loop
  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> macEn);
endmodule

bind ramfir_top ramfir_checker i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inI      (inI),
  .inQ      (inQ),
  .outValid (outValid),
  .outI     (outI),
  .outQ     (outQ),
  .sampleWe (stb.sampleWe),
  .bypass   (stb.bypass),
  .start    (stb.start),
  .macEn    (stb.macEn),
  .finish   (stb.finish),
  .coefIdx  (stb.coefIdx)
);

// File: tb/test_ramfir_top.sv
module test_ramfir_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 7;
  localparam int NSAMP = 34;
  localparam int WIN = 72;
  // tapsM1, rateM1, phase, sym, scale, amplitude mode (0 random, 1 max+, 2 max-)
  localparam int CFG_TAB [NCFG][6] = '{
    '{19,  0, 0, 0, 3, 0},
    '{63,  1, 1, 0, 2, 0},
    '{14,  0, 0, 1, 3, 0},
    '{127, 15, 7, 1, 1, 0},
    '{15,  1, 0, 1, 0, 0},
    '{15,  0, 0, 0, 3, 1},
    '{15,  0, 0, 0, 3, 2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [19:0] inI = '0, inQ = '0;
  logic regWe = 1'b0;
  logic [6:0] regAddr = '0;
  logic [19:0] regData = '0;
  logic outValid;
  logic signed [19:0] outI, outQ;

  int checks = 0, errors = 0;
  longint cycleCnt = 0, acceptCycle = 0, seenCycle = 0;
  int outSeen = 0;
  logic signed [19:0] seenI = '0, seenQ = '0;

  logic signed [19:0] refCoef [64];
  logic signed [19:0] refHistI [1024];
  logic signed [19:0] refHistQ [1024];
  int nSent = 0, cfgStart = 0;
  int cTapsM1 = 0, cRate = 0, cPhase = 0, cSym = 0, cScale = 3, cBypass = 0, cOff = 0;

  ramfir_top i_ramfir_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  always @(negedge clk) if (outValid) begin
    outSeen++;
    seenI = outI;
    seenQ = outQ;
    seenCycle = cycleCnt;
  end

  task automatic checkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(int addr, int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 7'(addr); regData = 20'(data);
    @(negedge clk);
    regWe = 1'b0;
    if (addr < 64) refCoef[addr] = 20'(data);
    else if (addr == 64) cTapsM1 = data & 127;
    else if (addr == 65) begin
      cRate = data & 15; cPhase = (data >> 4) & 15; cSym = (data >> 8) & 1;
      cScale = (data >> 9) & 3; cBypass = (data >> 11) & 1; cfgStart = nSent;
    end else if (addr == 66) cOff = data & 63;
  endtask

  task automatic driveSample(logic signed [19:0] vi, logic signed [19:0] vq);
    @(negedge clk);
    outSeen = 0;
    inValid = 1'b1; inI = vi; inQ = vq;
    refHistI[nSent] = vi; refHistQ[nSent] = vq;
    @(negedge clk);
    inValid = 1'b0;
    acceptCycle = cycleCnt;
    nSent++;
  endtask

  function automatic longint histAt(int idx, bit qPath);
    if (idx < 0) return 0;
    return qPath ? longint'(refHistQ[idx]) : longint'(refHistI[idx]);
  endfunction

  function automatic longint refOut(int n, int off, bit qPath);
    int nTap = cTapsM1 + 1;
    int nC = cSym ? (cTapsM1 >> 1) + 1 : nTap;
    int sh = 22 - cScale;
    longint acc = 0;
    for (int k = 0; k < nC; k++) begin
      longint x = histAt(n - k, qPath);
      if (cSym != 0 && (nTap - 1 - k) != k) x += histAt(n - (nTap - 1 - k), qPath);
      acc += longint'(refCoef[(off + k) % 64]) * x;
    end
    acc = (acc + (64'sd1 <<< (sh - 1))) >>> sh;
    if (acc > 524287) acc = 524287;
    if (acc < -524288) acc = -524288;
    return acc;
  endfunction

  function automatic int numCoef();
    return cSym ? (cTapsM1 >> 1) + 1 : cTapsM1 + 1;
  endfunction

  task automatic awaitResult(int cyc, bit expValid, longint eI, longint eQ,
                             longint eLat, string req);
    repeat (cyc) @(negedge clk);
    #1;
    checkEq(req, "output count", outSeen, expValid ? 1 : 0);
    if (expValid && outSeen == 1) begin
      checkEq(req, "I value", seenI, eI);
      checkEq(req, "Q value", seenQ, eQ);
      checkEq("R9", "latency", seenCycle - acceptCycle, eLat);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refCoef[i] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state and defaults
    checkEq("R1", "outValid", outValid, 0);
    checkEq("R1", "outI", outI, 0);
    checkEq("R1", "outQ", outQ, 0);
    driveSample(20'sd1000, -20'sd1000);
    awaitResult(10, 1'b1, 0, 0, 2, "R1");

    // table of configurations: R2 R3 R4 R5 R6 R9
    for (int c = 0; c < NCFG; c++) begin
      int amp = CFG_TAB[c][5];
      regWrite(64, CFG_TAB[c][0]);
      for (int i = 0; i < 64; i++)
        regWrite(i, (amp == 0) ? int'($urandom & 32'hFFFFF) : 524287);
      regWrite(65, CFG_TAB[c][1] | (CFG_TAB[c][2] << 4) | (CFG_TAB[c][3] << 8)
                   | (CFG_TAB[c][4] << 9));
      for (int s = 0; s < NSAMP; s++) begin
        logic signed [19:0] vi, vq;
        int n;
        bit trig;
        vi = (amp == 0) ? 20'($urandom) : (amp == 1) ? 20'sd524287 : -20'sd524288;
        vq = (amp == 0) ? 20'($urandom) : (amp == 1) ? 20'sd524287 : -20'sd524288;
        driveSample(vi, vq);
        n = nSent - 1;
        trig = (((n - cfgStart) % (cRate + 1)) == cPhase);
        awaitResult(WIN, trig, refOut(n, cOff, 1'b0), refOut(n, cOff, 1'b1),
                    numCoef() + 1, cSym ? "R5 R6 R4 R2" : "R3 R6 R4 R2");
      end
    end

    // R7: bypass with rate 4 and scale 00 set: every sample passes unchanged
    regWrite(65, 3 | (0 << 9) | (1 << 11));
    for (int s = 0; s < 3; s++) begin
      logic signed [19:0] vi, vq;
      vi = 20'($urandom); vq = 20'($urandom);
      driveSample(vi, vq);
      awaitResult(8, 1'b1, vi, vq, 0, "R7");
    end

    // R8: offset change while an output is being computed
    regWrite(65, 3 << 9);
    regWrite(64, 7);
    regWrite(66, 0);
    for (int i = 0; i < 8; i++) begin
      regWrite(i, int'($urandom & 32'hFFFFF));
      regWrite(32 + i, int'($urandom & 32'hFFFFF));
    end
    begin
      longint eI, eQ;
      int n;
      driveSample(20'sd123456, -20'sd77777);
      n = nSent - 1;
      eI = refOut(n, 0, 1'b0); eQ = refOut(n, 0, 1'b1);
      repeat (3) @(negedge clk);
      regWrite(66, 32);
      awaitResult(40, 1'b1, eI, eQ, 9, "R8");
      driveSample(-20'sd4321, 20'sd98765);
      n = nSent - 1;
      awaitResult(WIN, 1'b1, refOut(n, 32, 1'b0), refOut(n, 32, 1'b1), 9, "R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule